// File: doc/BRIEF.md
# Control Interface Mode Selector

This block decides, once per reset, how a shared control port operates. A self-boot strap is sampled while reset is held. A high strap puts the port into self-boot, where a loader engine masters the bus and reads settings from an external serial memory. A low strap puts it into I2C slave mode, which is the default.

From I2C mode, an external host can move the port into SPI slave mode. It does this by pulling the SPI chip-select/latch line low three separate times. The latch line is synchronised before use, and only its falling edges are counted. Once SPI mode is reached, it holds until the next reset.

The block drives a one-hot mode vector that enables exactly one of the three engines. It also drives per-pin output-enable and open-drain selects for the four shared control pins. The engines themselves are outside this block.

Top module: `ctlmode_sel`

## Requirements
- R1: With the strap high on the last clock edge of reset, `mode_o` is `3'b100` (self-boot) from the first cycle after reset release.
- R2: With the strap low on the last clock edge of reset, `mode_o` is `3'b001` (I2C slave) from the first cycle after reset release.
- R3: Changes on the strap input after reset release have no effect on `mode_o`.
- R4: In I2C mode, suppose the latch line is sampled low for the third time at clock edge k, after two earlier low periods. Then `mode_o` still reads I2C after edge k+1 and reads `3'b010` (SPI) after edge k+2.
- R5: In I2C mode, fewer than three falling edges of the latch line leave the port in I2C mode. A low level held for many cycles counts as one falling edge.
- R6: Once in SPI mode, the port stays in SPI mode until reset, whatever the latch line does.
- R7: In self-boot mode, latch line activity never changes `mode_o`.
- R8: Outside reset, `mode_o` always has exactly one bit set.
- R9: Pin selects per mode, with pin 0 as clock, pin 1 as data, pin 2 as the auxiliary pin and pin 3 as latch:
  - I2C: `pin_oe_o=4'b0010`, `pin_od_o=4'b0010`.
  - SPI: `pin_oe_o=4'b0100`, `pin_od_o=4'b0000`.
  - Self-boot: `pin_oe_o=4'b0011`, `pin_od_o=4'b0011`.
- R10: A new reset clears the falling-edge count and re-samples the strap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| selfboot_i | input | 1 | Self-boot strap, sampled during reset |
| latch_n_i | input | 1 | SPI latch/chip-select line, asynchronous, idle high |
| mode_o | output | 3 | One-hot mode: bit0 I2C, bit1 SPI, bit2 self-boot |
| pin_oe_o | output | 4 | Per shared pin: 1 = block may drive the pin |
| pin_od_o | output | 4 | Per shared pin: 1 = open-drain drive |

## Verification
The assertions check several properties on every cycle:
- the one-hot mode vector;
- the strap capture at reset release;
- that self-boot and SPI modes are sticky;
- that SPI is only ever entered from I2C;
- the pin-select pattern for each mode.

Only the bench scenarios can show the counting behaviour. These cover the exact two-edge latency of the third latch pulse, a long low counting once, fewer than three pulses leaving the mode alone, and a reset clearing a partial count.

// File: rtl/ctlmode_pkg.sv
// Package: shared mode encoding and pin indices for the control mode selector.
package ctlmode_pkg;

    localparam int MODE_W  = 3;
    localparam int PIN_CNT = 4;

    // Shared pin positions
    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_AUX = 2;
    localparam int PIN_LAT = 3;

    // One-hot control port mode
    typedef enum logic [MODE_W-1:0] {
        MODE_I2C  = 3'b001,
        MODE_SPI  = 3'b010,
        MODE_BOOT = 3'b100
    } ctl_mode_e;

endpackage

// File: rtl/ctlmode_sync.sv
// Module: ctlmode_sync
// Multi-flop synchroniser for an asynchronous level input.
// Assumes the input is slow relative to clk. Resets to RESET_VAL so that an
// idle-high line does not produce a false edge at reset release.
module ctlmode_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctlmode_fall_cnt.sv
// Module: ctlmode_fall_cnt
// Counts falling edges of a synchronised level while enabled, saturating at
// TARGET. hit_o pulses in the cycle the TARGET-th edge is seen.
// Assumes lvl_i is already synchronous to clk and idles high.
module ctlmode_fall_cnt #(
    parameter int TARGET = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(TARGET + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TARGET);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TARGET - 1);

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall;

    assign fall = prev_q & ~lvl_i;

    // Remember previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // Saturating falling-edge counter, gated by enable
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (en_i && fall && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = en_i & fall & (cnt_q == CNT_LAST);
endmodule

// File: rtl/ctlmode_ctrl.sv
// Module: ctlmode_ctrl
// Mode register. While reset is held, the register follows the strap, so it
// keeps the strap level of the last reset edge. After release, only the step
// from I2C to SPI is possible.
module ctlmode_ctrl
    import ctlmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_i,
    input  logic      spi_req_i,
    output ctl_mode_e mode_o,
    output logic      count_en_o
);
    ctl_mode_e mode_q;

    // Capture strap in reset; take the one-way step to SPI afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)                             mode_q <= strap_i ? MODE_BOOT : MODE_I2C;
        else if (mode_q == MODE_I2C && spi_req_i) mode_q <= MODE_SPI;
    end

    assign mode_o     = mode_q;
    assign count_en_o = (mode_q == MODE_I2C);
endmodule

// File: rtl/ctlmode_pinmux.sv
// Module: ctlmode_pinmux
// Maps the current mode onto output-enable and open-drain selects for the
// shared control pins. Purely combinational.
module ctlmode_pinmux
    import ctlmode_pkg::*;
(
    input  ctl_mode_e            mode_i,
    output logic [PIN_CNT-1:0]   oe_o,
    output logic [PIN_CNT-1:0]   od_o
);
    // Decode pin function per mode
    always_comb begin
        oe_o = '0;
        od_o = '0;
        unique case (mode_i)
            MODE_I2C: begin
                oe_o[PIN_DAT] = 1'b1;
                od_o[PIN_DAT] = 1'b1;
            end
            MODE_SPI: begin
                oe_o[PIN_AUX] = 1'b1;
            end
            MODE_BOOT: begin
                oe_o[PIN_CLK] = 1'b1;
                od_o[PIN_CLK] = 1'b1;
                oe_o[PIN_DAT] = 1'b1;
                od_o[PIN_DAT] = 1'b1;
            end
            default: begin
                oe_o = '0;
                od_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/ctlmode_sel.sv
// Module: ctlmode_sel (top)
// Control port mode selector. It samples the self-boot strap during reset,
// defaults to I2C and moves to SPI after SPI_PULSES latch falling edges.
// It drives a one-hot mode and pin selects.
// Assumes latch_n_i idles high during reset.
module ctlmode_sel
    import ctlmode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SPI_PULSES  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               selfboot_i,
    input  logic               latch_n_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic [PIN_CNT-1:0] pin_oe_o,
    output logic [PIN_CNT-1:0] pin_od_o
);
    logic      latch_sync;
    logic      spi_hit;
    logic      cnt_en;
    ctl_mode_e mode;

    ctlmode_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (latch_n_i),
        .q_o   (latch_sync)
    );

    ctlmode_fall_cnt #(.TARGET(SPI_PULSES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cnt_en),
        .lvl_i (latch_sync),
        .hit_o (spi_hit)
    );

    ctlmode_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (selfboot_i),
        .spi_req_i  (spi_hit),
        .mode_o     (mode),
        .count_en_o (cnt_en)
    );

    ctlmode_pinmux u_pinmux (
        .mode_i (mode),
        .oe_o   (pin_oe_o),
        .od_o   (pin_od_o)
    );

    assign mode_o = mode;
endmodule

// File: rtl/ctlmode_sel_chk.sv
// Module: ctlmode_sel_chk
// Assertion checker for ctlmode_sel, attached through bind below.
module ctlmode_sel_chk
    import ctlmode_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               selfboot_i,
    input logic [MODE_W-1:0]  mode_o,
    input logic [PIN_CNT-1:0] pin_oe_o,
    input logic [PIN_CNT-1:0] pin_od_o
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_o) == 1);

    a_r1_strap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mode_o == ($past(selfboot_i) ? MODE_BOOT : MODE_I2C));

    a_r7_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_BOOT |=> mode_o == MODE_BOOT);

    a_r6_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_SPI |=> mode_o == MODE_SPI);

    a_r3_only_i2c_to_spi: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$stable(mode_o)) |->
            ($past(mode_o) == MODE_I2C && mode_o == MODE_SPI));

    a_r9_pins_i2c: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_I2C |-> (pin_oe_o == 4'b0010 && pin_od_o == 4'b0010));

    a_r9_pins_spi: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_SPI |-> (pin_oe_o == 4'b0100 && pin_od_o == 4'b0000));

    a_r9_pins_boot: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_BOOT |-> (pin_oe_o == 4'b0011 && pin_od_o == 4'b0011));
endmodule

bind ctlmode_sel ctlmode_sel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .selfboot_i (selfboot_i),
    .mode_o     (mode_o),
    .pin_oe_o   (pin_oe_o),
    .pin_od_o   (pin_od_o)
);

// File: tb/ctlmode_sel_tb_top.sv
`timescale 1ns/1ps
module ctlmode_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       selfboot = 1'b0;
    logic       latch_n = 1'b1;
    logic [2:0] mode;
    logic [3:0] pin_oe;
    logic [3:0] pin_od;

    int  checks = 0;
    int  fails = 0;
    int  onehot_bad = 0;
    bit  armed = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ctlmode_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .selfboot_i (selfboot),
        .latch_n_i  (latch_n),
        .mode_o     (mode),
        .pin_oe_o   (pin_oe),
        .pin_od_o   (pin_od)
    );

    localparam logic [2:0] M_I2C = 3'b001, M_SPI = 3'b010, M_BOOT = 3'b100;

    function automatic logic [2:0] exp_mode(bit strap, int pulses);
        if (strap)            return M_BOOT;
        else if (pulses >= 3) return M_SPI;
        else                  return M_I2C;
    endfunction

    function automatic logic [7:0] exp_pins(logic [2:0] m);
        case (m)
            M_I2C:   return {4'b0010, 4'b0010};
            M_SPI:   return {4'b0100, 4'b0000};
            default: return {4'b0011, 4'b0011};
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check_mode(string req, logic [2:0] exp);
        checks++;
        if (mode !== exp) begin
            fails++;
            $display("FAIL %s mode=%b expected %b", req, mode, exp);
        end
    endtask

    task automatic check_pins(string req, logic [2:0] m);
        logic [7:0] e;
        e = exp_pins(m);
        checks++;
        if ({pin_oe, pin_od} !== e) begin
            fails++;
            $display("FAIL %s oe/od=%b expected %b", req, {pin_oe, pin_od}, e);
        end
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst_n = 1'b0; selfboot = strap; latch_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(int lo, int hi);
        latch_n = 1'b0;
        repeat (lo) @(negedge clk);
        latch_n = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Count one-hot violations outside reset (R8)
    always @(negedge clk) begin
        if (armed && rst_n && $countones(mode) != 1) onehot_bad++;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);

        // R1: strap high -> self-boot
        do_reset(1'b1);
        check_mode("R1", M_BOOT);
        check_pins("R9 boot", M_BOOT);

        // R7: latch pulses ignored in self-boot
        for (int i = 0; i < 5; i++) pulse(2, 2);
        settle();
        check_mode("R7", M_BOOT);

        // R2: strap low -> I2C
        do_reset(1'b0);
        check_mode("R2", M_I2C);
        check_pins("R9 i2c", M_I2C);

        // R3: strap change after release ignored
        selfboot = 1'b1;
        settle();
        check_mode("R3", M_I2C);

        // R5: two long lows count as two edges, stay I2C
        pulse(20, 3);
        pulse(20, 3);
        settle();
        check_mode("R5", M_I2C);

        // R4: exact latency of the third edge
        latch_n = 1'b0;          // sampled low at edge k
        @(posedge clk);          // k
        @(posedge clk); #1;      // k+1
        check_mode("R4 before", M_I2C);
        @(posedge clk); #1;      // k+2
        check_mode("R4 after", M_SPI);
        @(negedge clk);
        latch_n = 1'b1;
        settle();
        check_pins("R9 spi", M_SPI);

        // R6: SPI sticky under further pulses
        for (int i = 0; i < 4; i++) pulse(1, 1);
        settle();
        check_mode("R6", M_SPI);

        // R10: reset clears partial count
        do_reset(1'b0);
        pulse(2, 2); pulse(2, 2);
        do_reset(1'b0);
        pulse(2, 2); pulse(2, 2);
        settle();
        check_mode("R10 partial", M_I2C);
        pulse(2, 2);
        settle();
        check_mode("R10 third", M_SPI);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            bit strap;
            int n;
            string tag;
            strap = ($urandom % 3) == 0;
            n = $urandom % 6;
            do_reset(strap);
            if ($urandom % 2) selfboot = ~selfboot;
            for (int p = 0; p < n; p++) pulse(1 + $urandom % 3, 1 + $urandom % 3);
            settle();
            tag = strap ? "R7" : (n >= 3 ? "R6" : "R5");
            check_mode(tag, exp_mode(strap, n));
            check_pins("R9", exp_mode(strap, n));
        end

        // R8: one-hot throughout
        checks++;
        if (onehot_bad != 0) begin
            fails++;
            $display("FAIL R8 onehot violations=%0d expected 0", onehot_bad);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule